// File: doc/BRIEF.md
# Nonvolatile Memory Control Sequencer

The block sits between a CPU register bus and a behavioural memory array. Software steers it through four word registers: control, address, data and a key register. It reads words of program flash or bytes of a data EEPROM. It gathers flash words into a row of write latches and programs the whole row at once. It erases aligned rows to all ones and rewrites single EEPROM bytes. Program and erase cycles are timed inside the block. An operation only starts after a two-key unlock handshake.

Faults raise a sticky error bit, and only software clears it. Three cases are faults: a start aimed at a protected address, an unlock handshake that is broken, and a warm reset that lands in the middle of an operation. A power-on reset clears everything, including the error bit. A warm reset clears the registers but keeps the error bit, and it raises the error bit when it aborts an operation.

Register map on `bus_addr`: 0 = control, 1 = address, 2 = data, 3 = key. Control bits: bit0 read-start, bit1 write-start, bit2 write-enable, bit3 error, bit4 erase-enable, bit5 latch-only, bit6 region. Region 0 is flash and region 1 is EEPROM. Flash has 256 words, and addresses 0xE0 and above are protected. Rows are 32 words. EEPROM has 64 bytes; in region 1, addresses 64 and above are protected and read as 0.

Top module: `nvm_seq`

## Requirements
- R1: While `por_n` is low, control, address and data all read 0 and the unlock state returns to idle.
- R2: A control write with bit0 set, while write-start is 0, shows bit0 = 1 for exactly one cycle. The data register is then loaded from the current address and bit0 reads 0 again.
- R3: A write-start (control bit1 written as 1) is accepted only directly after key 0x55 and then key 0xAA are written to register 3 on consecutive bus accesses. Without that handshake, write-start stays 0.
- R4: Once accepted, write-start stays 1 for exactly 64 cycles for an erase, 32 for a row program and 40 for an EEPROM write, and then clears by itself.
- R5: While write-start is 1, software writes are ignored for write-start, for the mode bits (2, 4, 5, 6) and for the address and data registers.
- R6: A start at a protected address leaves write-start at 0 and sets the error bit.
- R7: After key 0x55, any access other than key 0xAA sets the error bit. After the full handshake, any access other than a control write with bit1 set also sets the error bit. A hardware set wins over a software write of 0 to the error bit in the same cycle.
- R8: Hardware never clears the error bit. A control write stores bit3 into it, both 0 and 1.
- R9: With erase-enable set in region 0, a start erases the 32-word aligned row that holds the address to all ones, whatever latch-only holds.
- R10: In region 0 with erase-enable 0 and latch-only 1, a start only copies the data register into the addressed word's latch; write-start stays 0. With latch-only 0, a start latches the word and then programs the whole row from the latches. Words never latched become all ones.
- R11: A start with write-enable (bit2) written as 0 does nothing and leaves memory unchanged.
- R12: In region 1, a start writes data bits 7:0 into the addressed EEPROM byte. A read in region 1 replaces only data bits 7:0.
- R13: A warm reset during an operation aborts it and leaves memory unchanged. After the reset, control reads 0x08 (only the error bit set) and the address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also clears the error bit |
| rst_n | input | 1 | Warm reset, active low, synchronous; keeps the error bit |
| bus_we | input | 1 | Bus write strobe, one access per cycle |
| bus_re | input | 1 | Bus read strobe; counts as an access for the unlock handshake |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register, combinational |

## Verification
Two events can land in the same cycle: a hardware error set and a software write of the error bit. The bench provokes this by writing key 0x55 and then, on the next access, a control word with the error bit at 0. That access breaks the handshake, and the bench expects the error bit to read 1 afterwards. A second pairing is a control write that arrives while write-start is still high. The bench sends one right after a start and judges that write-start and the address register both keep their values until the timed end.

// File: rtl/nvm_seq.sv
module nvm_seq #(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int ROW        = 32,
  parameter int EE_AW      = 6,
  parameter int PROT_START = 224,
  parameter int ERASE_CYC  = 64,
  parameter int PROG_CYC   = 32,
  parameter int EE_CYC     = 40,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int RB   = $clog2(ROW);
  localparam int FW   = 1 << AW;
  localparam int EEW  = 1 << EE_AW;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ((ERASE_CYC > EE_CYC) ? ERASE_CYC : EE_CYC)
                                               : ((PROG_CYC > EE_CYC) ? PROG_CYC : EE_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [AW-1:0] PROT_A = AW'(PROT_START);
  localparam logic [1:0] A_CTRL = 2'd0, A_ADDR = 2'd1, A_DATA = 2'd2, A_KEY = 2'd3;

  typedef enum logic [1:0] {K_ERASE, K_PROG, K_EE} kind_t;
  typedef enum logic [1:0] {U_IDLE, U_HALF, U_OPEN} ulk_t;

  logic rd, wr, wren, err, erase, lwlo, region, live;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic [CW-1:0] cnt;
  kind_t kind, kind_n;
  ulk_t  ulk, ulk_nxt;

  logic [DW-1:0] flash  [FW];
  logic [7:0]    eeprom [EEW];
  logic [DW-1:0] latch  [ROW];

  logic acc, ctrl_we, addr_we, data_we, key_we;
  logic try_go, prot, go, latch_only, launch, done, brk, hw_err, rd_go, ee_hit;

  assign acc     = bus_we | bus_re;
  assign ctrl_we = bus_we && bus_addr == A_CTRL;
  assign addr_we = bus_we && bus_addr == A_ADDR;
  assign data_we = bus_we && bus_addr == A_DATA;
  assign key_we  = bus_we && bus_addr == A_KEY;

  assign ee_hit     = addr[AW-1:EE_AW] == '0;
  assign try_go     = ctrl_we && bus_wdata[1] && ulk == U_OPEN && !wr;
  assign prot       = bus_wdata[6] ? !ee_hit : (addr >= PROT_A);
  assign go         = try_go && !prot && bus_wdata[2];
  assign latch_only = go && !bus_wdata[6] && !bus_wdata[4] && bus_wdata[5];
  assign launch     = go && !latch_only;
  assign done       = wr && cnt == '0;
  assign brk        = acc && ((ulk == U_HALF && !(key_we && bus_wdata[7:0] == KEY_B)) ||
                              (ulk == U_OPEN && !(ctrl_we && bus_wdata[1])));
  assign hw_err     = brk || (try_go && prot);
  assign rd_go      = ctrl_we && bus_wdata[0] && !wr && !rd && !try_go;
  assign kind_n     = bus_wdata[6] ? K_EE : (bus_wdata[4] ? K_ERASE : K_PROG);

  always_comb begin
    ulk_nxt = ulk;
    case (ulk)
      U_IDLE:  if (key_we && bus_wdata[7:0] == KEY_A) ulk_nxt = U_HALF;
      U_HALF:  if (acc) ulk_nxt = (key_we && bus_wdata[7:0] == KEY_B) ? U_OPEN : U_IDLE;
      default: if (acc) ulk_nxt = U_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      rd <= 1'b0; wr <= 1'b0; wren <= 1'b0; erase <= 1'b0; lwlo <= 1'b0; region <= 1'b0;
      err  <= por_n & (err | live);
      live <= 1'b0;
      addr <= '0; data <= '0; cnt <= '0;
      kind <= K_ERASE; ulk <= U_IDLE;
    end else begin
      if (hw_err) err <= 1'b1;
      else if (ctrl_we) err <= bus_wdata[3];
      if (launch) begin
        wr <= 1'b1; live <= 1'b1; kind <= kind_n;
        case (kind_n)
          K_ERASE: cnt <= CW'(ERASE_CYC - 1);
          K_PROG:  cnt <= CW'(PROG_CYC - 1);
          default: cnt <= CW'(EE_CYC - 1);
        endcase
      end else if (done) begin
        wr <= 1'b0; live <= 1'b0;
      end else if (wr) cnt <= cnt - 1'b1;
      rd <= rd_go;
      if (ctrl_we && !wr) begin
        wren <= bus_wdata[2]; erase <= bus_wdata[4]; lwlo <= bus_wdata[5]; region <= bus_wdata[6];
      end
      if (addr_we && !wr) addr <= bus_wdata[AW-1:0];
      if (rd) begin
        if (region) data[7:0] <= ee_hit ? eeprom[addr[EE_AW-1:0]] : 8'h00;
        else data <= flash[addr];
      end else if (data_we && !wr) data <= bus_wdata;
      ulk <= ulk_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (por_n && rst_n && done) begin
      case (kind)
        K_ERASE: for (int i = 0; i < ROW; i++) flash[{addr[AW-1:RB], RB'(i)}] <= '1;
        K_PROG:  for (int i = 0; i < ROW; i++) flash[{addr[AW-1:RB], RB'(i)}] <= latch[i];
        default: eeprom[addr[EE_AW-1:0]] <= data[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n || (done && kind == K_PROG))
      for (int i = 0; i < ROW; i++) latch[i] <= '1;
    else if (latch_only || (launch && kind_n == K_PROG))
      latch[addr[RB-1:0]] <= data;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(DW-7){1'b0}}, region, lwlo, erase, err, wren, wr, rd};
      A_ADDR:  bus_rdata = {{(DW-AW){1'b0}}, addr};
      A_DATA:  bus_rdata = data;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
  parameter int CW   = 7,
  parameter int MAXC = 64
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          bus_we,
  input logic          bus_re,
  input logic [1:0]    bus_addr,
  input logic          sw_wr,
  input logic          sw_err,
  input logic          rd,
  input logic          wr,
  input logic          wren,
  input logic          err,
  input logic [1:0]    ulk,
  input logic [CW-1:0] cnt
);
  logic [15:0] busy_len;
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n || !wr) busy_len <= '0;
    else busy_len <= busy_len + 16'd1;
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n || !rst_n) rd |=> !rd); // R2
  AST_START_AFTER_KEYS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(wr) |-> $past(ulk == 2'd2)); // R3
  AST_KEYS_SPENT: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (ulk == 2'd2 && (bus_we || bus_re)) |=> ulk == 2'd0); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wr |-> int'(busy_len) < MAXC); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr && cnt != '0) |=> wr); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (err && !(bus_we && bus_addr == 2'd0 && !sw_err)) |=> err); // R8
  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(wr) |-> wren); // R11
  AST_SW_START_ONLY_OPEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_we && bus_addr == 2'd0 && sw_wr && ulk != 2'd2 && !wr) |=> !wr); // R3
endmodule

bind nvm_seq nvm_seq_chk #(.CW(CW), .MAXC(MAXC)) i_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .sw_wr(bus_wdata[1]), .sw_err(bus_wdata[3]),
  .rd(rd), .wr(wr), .wren(wren), .err(err), .ulk(ulk), .cnt(cnt)
);

// File: tb/test_nvm_seq.sv
module test_nvm_seq;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0, bus_rdata;
  int checks = 0, fails = 0, cycles = 0;

  nvm_seq i_nvm_seq (.*);

  always #4 clk = ~clk;

  // behavioural reference model
  bit m_rd, m_wr, m_wren, m_err, m_erase, m_lwlo, m_region, m_live, m_dk = 1'b1;
  int m_addr, m_data, m_ulk, m_left, m_kind;
  logic [15:0] mf [256];
  bit mfk [256];
  logic [7:0] me [64];
  bit mek [64];
  logic [15:0] ml [32];

  always @(posedge clk) begin : model
    bit cw, kw, tr, pr, g, lo, ln, dn, br, rg, wo, rdgo, acc;
    int w, base;
    w = int'(bus_wdata);
    if (!por_n || !rst_n) begin
      m_err = por_n ? (m_err | m_live) : 1'b0;
      {m_rd, m_wr, m_wren, m_erase, m_lwlo, m_region, m_live} = '0;
      m_addr = 0; m_data = 0; m_dk = 1'b1; m_ulk = 0; m_left = 0;
      foreach (ml[i]) ml[i] = 16'hFFFF;
    end else begin
      wo  = m_wr;
      acc = bus_we | bus_re;
      cw  = bus_we && bus_addr == 2'd0;
      kw  = bus_we && bus_addr == 2'd3;
      tr  = cw && w[1] && m_ulk == 2 && !wo;
      rg  = w[6];
      pr  = rg ? (m_addr >= 64) : (m_addr >= 224);
      g   = tr && !pr && w[2];
      lo  = g && !rg && !w[4] && w[5];
      ln  = g && !lo;
      dn  = wo && m_left == 1;
      br  = acc && ((m_ulk == 1 && !(kw && w[7:0] == 8'hAA)) || (m_ulk == 2 && !(cw && w[1])));
      rdgo = cw && w[0] && !wo && !m_rd && !tr;
      base = m_addr - (m_addr % 32);
      if (dn) begin
        if (m_kind == 0) for (int i = 0; i < 32; i++) begin mf[base+i] = 16'hFFFF; mfk[base+i] = 1'b1; end
        else if (m_kind == 1) begin
          for (int i = 0; i < 32; i++) begin mf[base+i] = ml[i]; mfk[base+i] = 1'b1; ml[i] = 16'hFFFF; end
        end else begin me[m_addr] = m_data[7:0]; mek[m_addr] = 1'b1; end
      end
      if (lo || (ln && !rg && !w[4])) ml[m_addr % 32] = m_data[15:0];
      if (m_rd) begin
        if (m_region) begin
          if (m_addr < 64) begin m_data = (m_data & 32'hFF00) | int'(me[m_addr]); m_dk = m_dk && mek[m_addr]; end
          else m_data = m_data & 32'hFF00;
        end else begin m_data = int'(mf[m_addr]); m_dk = mfk[m_addr]; end
      end else if (bus_we && bus_addr == 2'd2 && !wo) begin m_data = w & 32'hFFFF; m_dk = 1'b1; end
      if (br || (tr && pr)) m_err = 1'b1;
      else if (cw) m_err = w[3];
      if (ln) begin
        m_wr = 1'b1; m_live = 1'b1;
        m_kind = rg ? 2 : (w[4] ? 0 : 1);
        m_left = rg ? 40 : (w[4] ? 64 : 32);
      end else if (dn) begin m_wr = 1'b0; m_live = 1'b0; end
      else if (wo) m_left--;
      if (cw && !wo) begin m_wren = w[2]; m_erase = w[4]; m_lwlo = w[5]; m_region = w[6]; end
      if (bus_we && bus_addr == 2'd1 && !wo) m_addr = w & 255;
      if (m_ulk == 0) begin if (kw && w[7:0] == 8'h55) m_ulk = 1; end
      else if (m_ulk == 1) begin if (acc) m_ulk = (kw && w[7:0] == 8'hAA) ? 2 : 0; end
      else if (acc) m_ulk = 0;
      m_rd = rdgo;
    end
  end

  always @(posedge clk) begin : compare
    int exp;
    bit skip;
    #2;
    cycles++;
    skip = 1'b0;
    case (bus_addr)
      2'd0: exp = {m_region, m_lwlo, m_erase, m_err, m_wren, m_wr, m_rd};
      2'd1: exp = m_addr;
      2'd2: begin exp = m_data; skip = !m_dk; end
      default: exp = 0;
    endcase
    if (!skip) begin
      checks++;
      if (int'(bus_rdata) != exp) begin
        fails++;
        case (bus_addr)
          2'd0: $display("FAIL R4 model control reg cycle %0d: got %h expected %h", cycles, bus_rdata, exp);
          2'd1: $display("FAIL R5 model address reg cycle %0d: got %h expected %h", cycles, bus_rdata, exp);
          2'd2: $display("FAIL R2 model data reg cycle %0d: got %h expected %h", cycles, bus_rdata, exp);
          default: $display("FAIL R3 model key reg cycle %0d: got %h expected %h", cycles, bus_rdata, exp);
        endcase
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R4 watchdog expired: got %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = we; bus_re = !we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic unlock_go(input logic [15:0] c);
    bus(1'b1, 2'd3, 16'h0055);
    bus(1'b1, 2'd3, 16'h00AA);
    bus(1'b1, 2'd0, c);
  endtask

  task automatic wait_done(output int n);
    logic [15:0] v;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rdreg(2'd0, v);
      if (!v[1]) break;
      n++;
    end
  endtask

  task automatic rd_word(input int a, input logic [15:0] modes, output logic [15:0] flag, output logic [15:0] v);
    bus(1'b1, 2'd1, 16'(a));
    bus(1'b1, 2'd0, modes | 16'h0001);
    rdreg(2'd0, flag);
    rdreg(2'd2, v);
  endtask

  initial begin
    logic [15:0] v, f;
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    rdreg(2'd0, v); check(v == 16'h0000, "R1", "control after power-on reset", v, 16'h0000);
    rdreg(2'd1, v); check(v == 16'h0000, "R1", "address after power-on reset", v, 16'h0000);

    bus(1'b1, 2'd0, 16'h0016);
    rdreg(2'd0, v); check(v == 16'h0014, "R3", "start without keys ignored", v, 16'h0014);

    bus(1'b1, 2'd1, 16'h0000);
    unlock_go(16'h0036);
    wait_done(n); check(n == 64, "R4", "erase busy cycles", n, 64);
    rd_word(5, 16'h0004, f, v);
    check(f[0] == 1'b1, "R2", "read-start visible one cycle", f, 16'h0005);
    check(v == 16'hFFFF, "R9", "erased word with latch-only set", v, 16'hFFFF);
    rdreg(2'd0, v); check(v[0] == 1'b0, "R2", "read-start self-cleared", v, 16'h0004);

    bus(1'b1, 2'd1, 16'h0003);
    bus(1'b1, 2'd2, 16'h1234);
    unlock_go(16'h0026);
    rdreg(2'd0, v); check(v == 16'h0024, "R10", "latch-only start leaves write-start 0", v, 16'h0024);
    bus(1'b1, 2'd1, 16'h0007);
    bus(1'b1, 2'd2, 16'hABCD);
    unlock_go(16'h0006);
    wait_done(n); check(n == 32, "R4", "program busy cycles", n, 32);
    rd_word(3, 16'h0004, f, v); check(v == 16'h1234, "R10", "latched word programmed", v, 16'h1234);
    rd_word(7, 16'h0004, f, v); check(v == 16'hABCD, "R10", "start word programmed", v, 16'hABCD);
    rd_word(4, 16'h0004, f, v); check(v == 16'hFFFF, "R10", "unlatched word all ones", v, 16'hFFFF);

    bus(1'b1, 2'd1, 16'h0020);
    unlock_go(16'h0016);
    bus(1'b1, 2'd0, 16'h0000);
    bus(1'b1, 2'd1, 16'h0055);
    rdreg(2'd0, v); check(v == 16'h0016, "R5", "software clear during busy ignored", v, 16'h0016);
    rdreg(2'd1, v); check(v == 16'h0020, "R5", "address write during busy ignored", v, 16'h0020);
    wait_done(n);
    rd_word(33, 16'h0004, f, v); check(v == 16'hFFFF, "R9", "second row erased", v, 16'hFFFF);

    bus(1'b1, 2'd1, 16'h00E0);
    unlock_go(16'h0016);
    rdreg(2'd0, v); check(v == 16'h001C, "R6", "protected start refused with error", v, 16'h001C);
    bus(1'b1, 2'd0, 16'h0004);
    rdreg(2'd0, v); check(v == 16'h0004, "R8", "software clears error", v, 16'h0004);
    bus(1'b1, 2'd0, 16'h000C);
    rdreg(2'd0, v); check(v == 16'h000C, "R8", "software sets error", v, 16'h000C);
    bus(1'b1, 2'd0, 16'h0004);

    bus(1'b1, 2'd3, 16'h0055);
    rdreg(2'd2, v);
    rdreg(2'd0, v); check(v == 16'h000C, "R7", "read after first key breaks handshake", v, 16'h000C);
    bus(1'b1, 2'd0, 16'h0004);
    bus(1'b1, 2'd3, 16'h0055);
    bus(1'b1, 2'd3, 16'h00AA);
    bus(1'b1, 2'd1, 16'h0010);
    rdreg(2'd0, v); check(v == 16'h000C, "R7", "address write after both keys breaks handshake", v, 16'h000C);
    bus(1'b1, 2'd0, 16'h0004);
    bus(1'b1, 2'd3, 16'h0055);
    bus(1'b1, 2'd0, 16'h0004);
    rdreg(2'd0, v); check(v == 16'h000C, "R7", "hardware set beats software clear", v, 16'h000C);
    bus(1'b1, 2'd0, 16'h0004);

    bus(1'b1, 2'd1, 16'h0003);
    unlock_go(16'h0012);
    rdreg(2'd0, v); check(v == 16'h0010, "R11", "start with write-enable 0 blocked", v, 16'h0010);
    rd_word(3, 16'h0000, f, v); check(v == 16'h1234, "R11", "memory unchanged when blocked", v, 16'h1234);

    bus(1'b1, 2'd1, 16'h0005);
    bus(1'b1, 2'd2, 16'h7E5A);
    unlock_go(16'h0046);
    wait_done(n); check(n == 40, "R12", "EEPROM busy cycles", n, 40);
    bus(1'b1, 2'd2, 16'hBB00);
    rd_word(5, 16'h0040, f, v); check(v == 16'hBB5A, "R12", "EEPROM read loads low byte only", v, 16'hBB5A);

    bus(1'b1, 2'd1, 16'h0003);
    unlock_go(16'h0016);
    idle();
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rdreg(2'd0, v); check(v == 16'h0008, "R13", "warm reset mid-erase flags error", v, 16'h0008);
    rdreg(2'd1, v); check(v == 16'h0000, "R13", "address cleared by warm reset", v, 16'h0000);
    bus(1'b1, 2'd0, 16'h0004);
    rd_word(3, 16'h0004, f, v); check(v == 16'h1234, "R13", "aborted erase left word intact", v, 16'h1234);
    idle();
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule